// File: doc/BRIEF.md
# Address-Masked GPIO Data Port

This block is a twelve-pin general-purpose I/O port on a plain 32-bit memory-mapped bus made of a byte address, a write enable, write data and read data. Its low address region is a data window of 4096 words. The word address inside that window acts as a per-pin mask. A single store can therefore raise, lower or leave alone any subset of pins, with no read-modify-write sequence and no risk of racing another agent that shares the port.

A direction word sets each pin as a driver or a receiver. The block drives the output value and the output enable of every pin. It samples the pin levels through a synchronizer, and reads return them gated by the same address mask. Pad drivers, pin multiplexing and interrupt logic live outside this block.

Read data is registered. It reflects the address present one clock earlier. There is no read strobe.

Top module: `gpio_mask_port`

## Requirements
- R1: On a write to the data window (byte address below 0x4000), each pin whose mask bit (word address bit n, byte address bit n+2) is 1 takes bit n of the write data. Each pin whose mask bit is 0 keeps its output value.
- R2: A read in the data window returns, in bit n, the synchronized level of pin n ANDed with mask bit n. Bits 31 to 12 and all unmasked bits read 0.
- R3: A read at byte address 0x3FFC (all mask bits 1) returns all twelve synchronized pin levels. A read at byte address (1<<n)<<2 returns pin n alone in bit n.
- R4: The direction word at byte address 0x8000 is read/write. It is written from write-data bits 11:0, and it reads back in bits 11:0 with bits 31:12 at 0.
- R5: pin_oe bit n equals direction bit n, where 1 means output. pin_out bit n equals the held output data bit n.
- R6: Every other address, including the reserved span 0x4000 to 0x7FFC and all addresses above 0x8000, reads as 0 and ignores writes.
- R7: Reset clears the direction word to all inputs, clears the output data to 0, and clears the read data.
- R8: A pin level change is seen through a two-flop synchronizer. It first appears in read data on the third rising edge after it is applied, provided the read address is held.
- R9: Read data comes one cycle after its address. A read of the direction word in the same cycle as a write to it returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address, bits 1:0 ignored |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pin_in | input | 12 | Raw pin levels |
| pin_out | output | 12 | Output values to the pads |
| pin_oe | output | 12 | Output enables to the pads, 1 means drive |

## Verification
Writes to the data window or the direction word show on pin_out and pin_oe right after the edge that takes them. Read data is due one edge after its address. A pin level is seen by a read three edges after it is applied. The bench drives every input at the falling edge. It updates its own model at each rising edge, keeping a short history queue of sampled pin values to cover the synchronizer delay. It compares all three outputs at every following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
   typedef enum logic [1:0] {
      REG_NONE = 2'd0,
      REG_WIN  = 2'd1,
      REG_DIR  = 2'd2
   } region_e;
endpackage

// File: rtl/gpio_mask_decode.sv
module gpio_mask_decode
   import gpio_mask_pkg::*;
#(
   parameter int NUM_PINS = 12,
   parameter int ADDR_W   = 16
) (
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   output region_e             sel,
   output logic [NUM_PINS-1:0] mask,
   output logic                win_we,
   output logic                dir_we
);
   localparam int WORD_W = ADDR_W - 2;
   localparam logic [WORD_W-1:0] DIR_WORD = WORD_W'(2) << NUM_PINS;

   logic [WORD_W-1:0] word;
   assign word = addr[ADDR_W-1:2];
   assign mask = word[NUM_PINS-1:0];

   always_comb begin
      if (word[WORD_W-1:NUM_PINS] == '0) sel = REG_WIN;
      else if (word == DIR_WORD)         sel = REG_DIR;
      else                               sel = REG_NONE;
   end

   assign win_we = we && (sel == REG_WIN);
   assign dir_we = we && (sel == REG_DIR);
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int WIDTH  = 12,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage[0] <= '0;
            else        stage[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage[s] <= '0;
            else        stage[s] <= stage[s-1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int NUM_PINS = 12,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                win_we,
   input  logic                dir_we,
   input  logic [NUM_PINS-1:0] mask,
   input  logic [DATA_W-1:0]   wdata,
   output logic [NUM_PINS-1:0] out_q,
   output logic [NUM_PINS-1:0] dir_q
);
   logic [NUM_PINS-1:0] wbits;
   assign wbits = wdata[NUM_PINS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
      end else begin
         if (win_we) out_q <= (out_q & ~mask) | (wbits & mask);
         if (dir_we) dir_q <= wbits;
      end
   end

   assert_unmasked_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
      win_we |=> ((out_q & ~$past(mask)) == ($past(out_q) & ~$past(mask))));
   assert_masked_taken_R1: assert property (@(posedge clk) disable iff (!rst_n)
      win_we |=> ((out_q & $past(mask)) == ($past(wbits) & $past(mask))));
   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !win_we |=> $stable(out_q));
   assert_dir_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dir_we |=> $stable(dir_q));
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path
   import gpio_mask_pkg::*;
#(
   parameter int NUM_PINS = 12,
   parameter int DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  region_e             sel,
   input  logic [NUM_PINS-1:0] mask,
   input  logic [NUM_PINS-1:0] pins_sync,
   input  logic [NUM_PINS-1:0] dir_q,
   output logic [DATA_W-1:0]   rdata
);
   logic [NUM_PINS-1:0] low_next;

   always_comb begin
      unique case (sel)
         REG_WIN: low_next = pins_sync & mask;
         REG_DIR: low_next = dir_q;
         default: low_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= DATA_W'(low_next);
   end

   assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rdata[DATA_W-1:NUM_PINS] == '0);
   assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_NONE) |=> (rdata == '0));
   assert_unmasked_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == REG_WIN) |=> ((rdata[NUM_PINS-1:0] & ~$past(mask)) == '0));
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
   import gpio_mask_pkg::*;
#(
   parameter int NUM_PINS    = 12,
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe
);
   initial begin
      assert (DATA_W > NUM_PINS) else $error("gpio_mask_port: DATA_W must exceed NUM_PINS");
      assert (ADDR_W >= NUM_PINS + 4) else $error("gpio_mask_port: ADDR_W too small for window and direction word");
   end

   region_e             sel;
   logic [NUM_PINS-1:0] mask, pins_sync, out_q, dir_q;
   logic                win_we, dir_we;

   gpio_mask_decode #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_decode (
      .addr(bus_addr), .we(bus_we), .sel(sel), .mask(mask),
      .win_we(win_we), .dir_we(dir_we)
   );

   gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
   );

   gpio_port_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .win_we(win_we), .dir_we(dir_we),
      .mask(mask), .wdata(bus_wdata), .out_q(out_q), .dir_q(dir_q)
   );

   gpio_read_path #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_read (
      .clk(clk), .rst_n(rst_n), .sel(sel), .mask(mask),
      .pins_sync(pins_sync), .dir_q(dir_q), .rdata(bus_rdata)
   );

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   assert_reset_clear_R7: assert property (@(posedge clk)
      !rst_n |=> (pin_out == '0 && pin_oe == '0 && bus_rdata == '0));
   assert_dir_rdback_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == ADDR_W'(2) << (NUM_PINS + 2)) |=> (bus_rdata[NUM_PINS-1:0] == $past(pin_oe)));
endmodule

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [11:0] pin_in = '0;
   logic [11:0] pin_out, pin_oe;

   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;
   string cur_req = "R7";

   logic [11:0] m_out = '0, m_dir = '0;
   logic [31:0] m_rd = '0;
   logic [11:0] hist[$] = '{12'h0, 12'h0};

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_mask_port u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // Behavioural reference: window below 0x4000, direction word at 0x8000, rest dead.
   always @(posedge clk) begin
      logic [11:0] msk;
      msk = bus_addr[13:2];
      if (!rst_n) begin
         m_out = '0; m_dir = '0; m_rd = '0;
         hist = '{12'h0, 12'h0};
      end else begin
         if (bus_addr < 16'h4000)       m_rd = {20'h0, hist[1] & msk};
         else if (bus_addr == 16'h8000) m_rd = {20'h0, m_dir};
         else                           m_rd = '0;
         if (bus_we) begin
            if (bus_addr < 16'h4000)       m_out = (m_out & ~msk) | (bus_wdata[11:0] & msk);
            else if (bus_addr == 16'h8000) m_dir = bus_wdata[11:0];
         end
         hist.push_front(pin_in);
         void'(hist.pop_back());
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_cmp++;
         if (pin_out !== m_out) begin
            n_bad++;
            $display("FAIL %s/R5 pin_out actual %h expected %h", cur_req, pin_out, m_out);
         end
         n_cmp++;
         if (pin_oe !== m_dir) begin
            n_bad++;
            $display("FAIL %s/R5 pin_oe actual %h expected %h", cur_req, pin_oe, m_dir);
         end
         n_cmp++;
         if (bus_rdata !== m_rd) begin
            n_bad++;
            $display("FAIL %s bus_rdata actual %h expected %h", cur_req, bus_rdata, m_rd);
         end
      end
   end

   task automatic cyc(input logic [15:0] a, input logic we, input logic [31:0] d);
      bus_addr = a; bus_we = we; bus_wdata = d;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R7";                      // reset state checked on the above negedges
      rst_n = 1'b1;
      cyc(16'h0000, 1'b0, '0);
      cur_req = "R1";                      // full-mask then partial-mask writes
      cyc(16'h3FFC, 1'b1, 32'hFFFF_FA5A);
      cyc(16'h003C, 1'b1, 32'h0000_0FF0);  // mask 0x00F: only pins 3:0
      cyc(16'h3C00, 1'b1, 32'h0000_0000);  // mask 0xF00: clears pins 11:8
      cyc(16'h0000, 1'b1, 32'hFFFF_FFFF);  // mask 0: nothing changes
      cur_req = "R4";
      cyc(16'h8000, 1'b1, 32'hFFFF_F0F3);
      cyc(16'h8000, 1'b0, '0);
      cur_req = "R9";                      // read-during-write returns the old value
      cyc(16'h8000, 1'b1, 32'h0000_0555);
      cyc(16'h8000, 1'b0, '0);
      cur_req = "R8";                      // pin change with full-mask read held
      pin_in = 12'hB6D;
      repeat (5) cyc(16'h3FFC, 1'b0, '0);
      cur_req = "R3";
      for (int n = 0; n < 12; n++) cyc(16'((1 << n) << 2), 1'b0, '0);
      cur_req = "R2";
      cyc(16'h2AA8, 1'b0, '0);
      cyc(16'h1554, 1'b0, '0);
      cur_req = "R6";
      cyc(16'h4000, 1'b1, 32'hFFFF_FFFF);
      cyc(16'h7FFC, 1'b1, 32'hFFFF_FFFF);
      cyc(16'h8004, 1'b1, 32'hFFFF_FFFF);
      cyc(16'hFFFC, 1'b1, 32'hFFFF_FFFF);
      cyc(16'h4000, 1'b0, '0);
      cur_req = "R1/R2 mix";
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] a;
         a = 16'($urandom) & 16'hFFFC;
         if (($urandom % 4) == 0) a = 16'h8000;
         if (($urandom % 8) == 0) pin_in = 12'($urandom);
         cyc(a, 1'($urandom), $urandom);
      end
      cur_req = "R7";
      rst_n = 1'b0;
      repeat (2) cyc(16'h3FFC, 1'b0, '0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule